// File: doc/BRIEF.md
# Synchronous Flash Burst Read Sequencer

This block is the read side of a synchronous NOR-style flash model. A read starts when `start` is sampled high while the chip is enabled. The block captures the start address, the burst mode, the wrap choice and the first-access latency. It then holds the wait indication through the latency. After that it presents one word per clock from a small behavioural storage array, and raises the wait indication again once the burst has ended.

Raising output enable pauses the sequence. This models a bus master that stops the clock: the address, the latency count and the word count are all frozen. When output enable returns low, reading carries on from the word that was showing when the pause began. Single-read mode, and any read of the identification space, keep one word on the bus for the whole access and never step the address. The block does not drive pads. It reports drive enables for the data bus and for the wait line, and the pad ring performs the tri-stating.

Top module: `fbr_read_ctrl`

## Requirements
- R1: After reset the block is idle, and `ready_wait` is 1 whenever it is enabled; no data word is reported valid until a read has been started.
- R2: The latency input L is clamped to the range 2..7, so 0 and 1 act as 2. After the edge that samples `start`, `ready_wait` is 1 for exactly L-1 cycles, and the first word is presented from the L-th edge onward, counting the sampling edge as the first.
- R3: `mode` encodes the access type: 01 gives 4 words, 10 gives 8 words, 11 gives 16 words, and 00 is a single read. A burst presents that many consecutive words with `ready_wait` at 0, one word per unpaused clock.
- R4: After the last word of a burst, `ready_wait` goes to 1 and stays at 1 until a new read is started.
- R5: With `wrap_en` at 1, the address after A is (A & ~M) | ((A+1) & M), where M is the burst length minus one. With `wrap_en` at 0 the address counts up linearly modulo the array depth.
- R6: While `oe_n` is 1, the latency count, the word count and the address are all frozen. When `oe_n` returns to 0, the same word is presented again, and stepping resumes from it.
- R7: In single-read mode, the word at the start address stays on `dout` and `ready_wait` stays at 0 until the next read or until the chip is disabled.
- R8: A read started with `id_sel` at 1 is always a single read, whatever `mode` says. It returns identification word 0x8900 + (start address mod 4).
- R9: `dout_oe` is 1 exactly when both `ce_n` and `oe_n` are 0.
- R10: `wait_oe` is 1 when `ce_n` is 0 and either `wait_gated` is 0 or `oe_n` is 0; otherwise it is 0.
- R11: `ce_n` at 1 on an edge sends the block back to idle. A `start` pulse sampled while `ce_n` is 1 is ignored.
- R12: The storage word at address a is (a * 0x0101) XOR 0x5A3C, truncated to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a read using the current address and settings |
| start_addr | input | AW | Word address of the first access |
| mode | input | 2 | 00 single, 01 four, 10 eight, 11 sixteen words |
| latency | input | LW | First-access latency in clocks (clamped to 2..7) |
| wrap_en | input | 1 | 1: wrap inside the aligned burst; 0: linear |
| id_sel | input | 1 | Read the identification space (single read) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; high pauses the sequence |
| wait_gated | input | 1 | 1: wait line drive also requires output enable |
| dout | output | DW | Read data |
| dout_oe | output | 1 | Drive enable for the data bus |
| ready_wait | output | 1 | Wait indication, active high (1 = data not valid) |
| wait_oe | output | 1 | Drive enable for the wait line |

## Verification
The bench uses the defaults: AW=6, DW=16 and LW=3. The 64-word array is small enough that a 16-word linear burst from address 61 crosses the top of the address space and rolls over to 0. The 3-bit latency field lets the bench apply both clamped values (0 and 1) and the largest latency (7). The 6-bit address also lets one array hold bursts of every length, each wrapping inside its own aligned boundary.

// File: rtl/fbr_pkg.sv
// Shared types and helpers for the flash burst read sequencer.
// Assumes burst lengths are powers of two no larger than 16.
package fbr_pkg;
    timeunit 1ns; timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAT    = 3'd1,
        ST_DATA   = 3'd2,
        ST_END    = 3'd3,
        ST_SINGLE = 3'd4
    } fbr_state_e;

    localparam logic [1:0] MD_SINGLE = 2'b00;
    localparam logic [1:0] MD_B4     = 2'b01;
    localparam logic [1:0] MD_B8     = 2'b10;
    localparam logic [1:0] MD_B16    = 2'b11;

    localparam int LAT_MIN = 2;
    localparam int CNT_W   = 4;

    // Burst length minus one for a mode code; single read gives zero.
    function automatic logic [CNT_W-1:0] burst_mask(input logic [1:0] md);
        case (md)
            MD_B4:   return 4'd3;
            MD_B8:   return 4'd7;
            MD_B16:  return 4'd15;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/fbr_seq.sv
// Read sequencer: latches the access settings at start, counts the
// first-access latency, counts burst words and freezes while output
// enable is high. Assumes start_ok already includes chip enable.
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic [1:0]       mode_in,
    input  logic [LW-1:0]    lat_in,
    input  logic             id_in,
    output fbr_state_e       state_q,
    output logic [CNT_W-1:0] mask_q,
    output logic             id_q,
    output logic             load,
    output logic             step
);
    timeunit 1ns; timeprecision 1ps;

    logic [LW-1:0]    lat_eff;
    logic [LW-1:0]    lat_cnt;
    logic [CNT_W-1:0] wcnt;
    logic             single_q;
    logic             last_word;
    logic             run;

    // Clamp latency, detect the final word and the unpaused condition.
    always_comb begin
        lat_eff   = (lat_in < LW'(LAT_MIN)) ? LW'(LAT_MIN) : lat_in;
        last_word = (wcnt == mask_q);
        run       = !oe_n && !ce_n;
    end

    assign load = start_ok;
    assign step = (state_q == ST_DATA) && run && !last_word && !start_ok;

    // State, latency counter and word counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lat_cnt  <= '0;
            wcnt     <= '0;
            mask_q   <= '0;
            id_q     <= 1'b0;
            single_q <= 1'b0;
        end else if (start_ok) begin
            state_q  <= ST_LAT;
            lat_cnt  <= lat_eff - LW'(1);
            wcnt     <= '0;
            id_q     <= id_in;
            single_q <= id_in || (mode_in == MD_SINGLE);
            mask_q   <= id_in ? '0 : burst_mask(mode_in);
        end else if (ce_n) begin
            state_q  <= ST_IDLE;
        end else if (run) begin
            case (state_q)
                ST_LAT: begin
                    if (lat_cnt == LW'(1))
                        state_q <= single_q ? ST_SINGLE : ST_DATA;
                    else
                        lat_cnt <= lat_cnt - LW'(1);
                end
                ST_DATA: begin
                    if (last_word) state_q <= ST_END;
                    else           wcnt    <= wcnt + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !ce_n && !start_ok) |=> ($stable(state_q) && $stable(wcnt) && $stable(lat_cnt)));

    assert_lat_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAT) |-> (lat_cnt != '0));

    assert_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END && !start_ok && !ce_n) |=> (state_q == ST_END));

    assert_word_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (wcnt <= mask_q));
endmodule

// File: rtl/fbr_addr.sv
// Burst address generator: loads the start address and wrap choice,
// then advances either inside the aligned burst window or linearly.
// Assumes AW is at least the width of the burst mask.
module fbr_addr
    import fbr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [AW-1:0]    start_addr,
    input  logic             wrap_in,
    input  logic [CNT_W-1:0] mask,
    output logic [AW-1:0]    cur_q
);
    timeunit 1ns; timeprecision 1ps;

    logic [AW-1:0] mask_ext;
    logic [AW-1:0] nxt;
    logic          wrap_q;

    // Compute the successor address for the latched wrap choice.
    always_comb begin
        mask_ext = AW'(mask);
        if (wrap_q)
            nxt = (cur_q & ~mask_ext) | ((cur_q + AW'(1)) & mask_ext);
        else
            nxt = cur_q + AW'(1);
    end

    // Address register: load at start, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            cur_q  <= start_addr;
            wrap_q <= wrap_in;
        end else if (step) begin
            cur_q  <= nxt;
        end
    end

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_q));

    assert_wrap_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_q && !load) |=> ((cur_q & ~mask_ext) == $past(cur_q & ~mask_ext)));
endmodule

// File: rtl/fbr_array.sv
// Behavioural storage: a register per word, filled with a computed
// pattern at reset, plus a small identification space.
// Assumes DW is at least 16.
module fbr_array #(
    parameter int AW  = 6,
    parameter int DW  = 16,
    parameter int IDW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          id_sel,
    output logic [DW-1:0] rd_data
);
    timeunit 1ns; timeprecision 1ps;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Fill pattern for one storage word.
    function automatic logic [DW-1:0] fill_word(input int a);
        return (DW'(a) * DW'(16'h0101)) ^ DW'(16'h5A3C);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        // Load this word's pattern at reset and hold it.
        always_ff @(posedge clk) begin
            if (!rst_n) mem[g] <= fill_word(g);
        end
    end

    // Select the identification word or the storage word.
    always_comb begin
        if (id_sel)
            rd_data = DW'(16'h8900) + DW'(rd_addr[IDW-1:0]);
        else
            rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/fbr_read_ctrl.sv
// Top of the synchronous flash read path. Joins the sequencer, the
// address generator and the storage array, and derives the wait flag
// and the pad drive enables. Assumes the pads do the tri-stating.
module fbr_read_ctrl
    import fbr_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    mode,
    input  logic [LW-1:0] latency,
    input  logic          wrap_en,
    input  logic          id_sel,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          wait_gated,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          ready_wait,
    output logic          wait_oe
);
    timeunit 1ns; timeprecision 1ps;

    fbr_state_e       state;
    logic [CNT_W-1:0] mask;
    logic             id_q;
    logic             load;
    logic             step;
    logic             start_ok;
    logic [AW-1:0]    cur_addr;

    assign start_ok = start && !ce_n;

    fbr_seq #(.LW(LW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .mode_in  (mode),
        .lat_in   (latency),
        .id_in    (id_sel),
        .state_q  (state),
        .mask_q   (mask),
        .id_q     (id_q),
        .load     (load),
        .step     (step)
    );

    fbr_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .start_addr (start_addr),
        .wrap_in    (wrap_en),
        .mask       (mask),
        .cur_q      (cur_addr)
    );

    fbr_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (cur_addr),
        .id_sel  (id_q),
        .rd_data (dout)
    );

    // Wait flag is low only while a valid word is presented; pad enables.
    always_comb begin
        ready_wait = !((state == ST_DATA) || (state == ST_SINGLE));
        dout_oe    = !ce_n && !oe_n;
        wait_oe    = !ce_n && (!wait_gated || !oe_n);
    end

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ready_wait);

    assert_pause_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !ce_n && !start && !ready_wait) |=> ($stable(dout) && !ready_wait));
endmodule

// File: tb/fbr_read_ctrl_bench.sv
module fbr_read_ctrl_bench;
    timeunit 1ns; timeprecision 1ps;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    mode = 2'b00;
    logic [LW-1:0] latency = 3'd2;
    logic          wrap_en = 1'b0;
    logic          id_sel = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          wait_gated = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          ready_wait;
    logic          wait_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fbr_read_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_fbr_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mode(mode), .latency(latency), .wrap_en(wrap_en), .id_sel(id_sel),
        .ce_n(ce_n), .oe_n(oe_n), .wait_gated(wait_gated), .dout(dout),
        .dout_oe(dout_oe), .ready_wait(ready_wait), .wait_oe(wait_oe)
    );

    // Vector fields: {addr[5:0], mode[1:0], latency[2:0], wrap, id}
    localparam logic [12:0] VEC [0:6] = '{
        {6'd5,  2'b01, 3'd3, 1'b1, 1'b0},
        {6'd13, 2'b10, 3'd2, 1'b1, 1'b0},
        {6'd61, 2'b11, 3'd7, 1'b0, 1'b0},
        {6'd22, 2'b11, 3'd4, 1'b1, 1'b0},
        {6'd9,  2'b00, 3'd5, 1'b0, 1'b0},
        {6'd6,  2'b11, 3'd0, 1'b0, 1'b1},
        {6'd2,  2'b01, 3'd1, 1'b0, 1'b0}
    };

    function automatic logic [15:0] word_at(input logic [5:0] a);
        return {2'b00, a, 2'b00, a} ^ 16'h5A3C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic run_read(input logic [5:0] a0, input logic [1:0] md,
                            input logic [2:0] lat, input logic wr, input logic id);
        int leff;
        int len;
        logic [5:0] m;
        logic [5:0] a;
        ce_n = 1'b0; oe_n = 1'b0;
        start_addr = a0; mode = md; latency = lat; wrap_en = wr; id_sel = id;
        start = 1'b1;
        tick();
        start = 1'b0;
        leff = (lat < 2) ? 2 : int'(lat);
        for (int i = 0; i < leff - 1; i++) begin
            check("R2 latency wait", ready_wait, 1'b1);
            tick();
        end
        if (id) begin
            for (int k = 0; k < 5; k++) begin
                check("R8 id word", dout, 16'h8900 + a0[1:0]);
                check("R8 id single", ready_wait, 1'b0);
                tick();
            end
        end else if (md == 2'b00) begin
            for (int k = 0; k < 5; k++) begin
                check("R7 single word", dout, word_at(a0));
                check("R7 single wait", ready_wait, 1'b0);
                tick();
            end
        end else begin
            len = 4 << (md - 1);
            m = 6'(len - 1);
            for (int k = 0; k < len; k++) begin
                a = wr ? ((a0 & ~m) | ((a0 + 6'(k)) & m)) : (a0 + 6'(k));
                if (k == 0) check("R12 first word", dout, word_at(a));
                else if (wr) check("R5 wrapped word", dout, word_at(a));
                else check("R3 burst word", dout, word_at(a));
                check("R3 wait low", ready_wait, 1'b0);
                tick();
            end
            check("R4 end wait", ready_wait, 1'b1);
            tick();
            check("R4 end held", ready_wait, 1'b1);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check("R9 oe in reset", dout_oe, 1'b0);
        check("R10 wait oe in reset", wait_oe, 1'b0);
        rst_n = 1'b1;
        tick();
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check("R1 idle wait", ready_wait, 1'b1);
        check("R9 oe enabled", dout_oe, 1'b1);
        check("R10 wait oe enabled", wait_oe, 1'b1);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R1 idle no data", ready_wait, 1'b1);
        end

        // Table-driven reads.
        for (int v = 0; v < 7; v++) begin
            run_read(VEC[v][12:7], VEC[v][6:5], VEC[v][4:2], VEC[v][1], VEC[v][0]);
            tick();
        end

        // R6 pause and resume.
        ce_n = 1'b0; oe_n = 1'b0; wait_gated = 1'b1;
        start_addr = 6'd20; mode = 2'b11; latency = 3'd2; wrap_en = 1'b0; id_sel = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        check("R2 one latency cycle", ready_wait, 1'b1);
        tick();
        check("R6 word before pause", dout, word_at(6'd20));
        tick();
        check("R6 word before pause", dout, word_at(6'd21));
        oe_n = 1'b1;
        #1;
        check("R9 oe off", dout_oe, 1'b0);
        check("R10 gated wait off", wait_oe, 1'b0);
        wait_gated = 1'b0;
        #0.5;
        check("R10 ungated wait on", wait_oe, 1'b1);
        repeat (3) tick();
        oe_n = 1'b0; wait_gated = 1'b1;
        #1;
        check("R6 resumed word", dout, word_at(6'd21));
        check("R6 resumed wait", ready_wait, 1'b0);
        tick();
        check("R6 next after resume", dout, word_at(6'd22));

        // R11 abort by chip disable.
        ce_n = 1'b1;
        tick();
        ce_n = 1'b0;
        #1;
        for (int i = 0; i < 4; i++) begin
            check("R11 abort idle", ready_wait, 1'b1);
            tick();
        end

        // R11 start ignored while disabled.
        ce_n = 1'b1; start = 1'b1; mode = 2'b00; latency = 3'd2; start_addr = 6'd3;
        tick();
        start = 1'b0; ce_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check("R11 start ignored", ready_wait, 1'b1);
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule